// File: doc/BRIEF.md
# Floating-Point Unit State Initialization Controller

This block holds the architectural control state of a stack-based floating-point unit: the control word, the status word, the tag word, the last instruction and data pointers and the last opcode. It carries out a decoded initialize command that comes in two forms. The non-waiting form resets that state at once. The waiting form runs as a wait step followed by the non-waiting step, and each step can be rejected on its own. The eight data registers are not held here, so an initialize leaves them untouched. They become unreachable only because every tag is forced to the empty code.

A command arrives on a valid/ready handshake with a wait flag and a lock-prefix flag. Two system-control bits (emulation and task-switched) and a pending-unmasked-exception flag come in as side inputs. Each command ends with a one-cycle done pulse and a fault code. The code is zero on success. A rejected command changes no register. A generic load port lets a test environment preset any register while no command is in flight.

Top module: `fpu_init_ctrl`

## Requirements
- R1: A successful initialize sets the control word to 16'h037F, the status word to zero (top-of-stack and C0..C3 cleared), every 2-bit tag to 2'b11 (tag word all ones), and the instruction pointer, data pointer and last opcode to zero.
- R2: After the asynchronous active-low reset, all registers hold the values of R1, cmd_ready is high and done is low.
- R3: A non-waiting command accepted at a clock edge updates the registers at that same edge and raises done for the following cycle. cmd_ready stays high and exc_pending is ignored.
- R4: A waiting command accepted while exc_pending is high raises done in the next cycle with a math fault, and no register changes.
- R5: A waiting command with no pending exception holds cmd_ready low for one cycle, then completes with done two cycles after acceptance. In its second step exc_pending is ignored.
- R6: If sys_em or sys_ts is high when a step is evaluated, that step ends with a device-not-available fault and no register changes. This holds for the acceptance step and for the second step of the waiting form.
- R7: A command with cmd_lock set ends with an invalid-opcode fault and no register change. Priority is invalid-opcode over device-not-available over math fault.
- R8: fault_code is 0 for success, 1 for invalid-opcode, 2 for device-not-available and 3 for math fault. fault_code is valid only while done is high. Exactly one of fault_ud, fault_nm, fault_mf pulses with a rejected done, and none pulses otherwise.
- R9: ld_en with ld_sel writes ld_data into one register in the cycle after the edge. The codes are 0 control, 1 status, 2 tag, 3 instruction pointer, 4 data pointer and 5 opcode; 6 and 7 write nothing. Each register takes the low bits of ld_data.
- R10: A load is ignored in a cycle where a command is accepted and during the second step of a waiting command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Initialize request present |
| cmd_ready | output | 1 | Controller can accept a request |
| cmd_wait | input | 1 | Request is the waiting form |
| cmd_lock | input | 1 | Request carries a lock prefix |
| sys_em | input | 1 | System emulation bit |
| sys_ts | input | 1 | System task-switched bit |
| exc_pending | input | 1 | Unmasked floating-point exception pending |
| ld_en | input | 1 | Preload strobe |
| ld_sel | input | 3 | Preload target register code |
| ld_data | input | PTR_W | Preload value |
| ctrl_word | output | 16 | Control word |
| stat_word | output | 16 | Status word |
| tag_word | output | 2*NUM_TAGS | Tag word |
| last_ip | output | PTR_W | Last instruction pointer |
| last_dp | output | PTR_W | Last data pointer |
| last_op | output | OP_W | Last opcode |
| done | output | 1 | Command completion pulse |
| fault_code | output | 2 | Completion result code |
| fault_ud | output | 1 | Invalid-opcode fault pulse |
| fault_nm | output | 1 | Device-not-available fault pulse |
| fault_mf | output | 1 | Math fault pulse |

## Verification
The bench builds the block with PTR_W = 48, OP_W = 11 and NUM_TAGS = 8. The pointer width goes beyond the 32-bit default, so a preload can set bits that a narrow build would not hold, and the bench checks that an initialize clears the upper half of both pointers. With eight tags the tag word is 16 bits wide, so a preload of zero followed by an initialize exercises the change of every tag to the empty code. A preload of the control and status words before each command makes the no-change rule on every fault path visible at the ports.

// File: rtl/fpu_init_pkg.sv
package fpu_init_pkg;

    localparam logic [15:0] CW_INIT = 16'h037F;
    localparam logic [15:0] SW_INIT = 16'h0000;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_UD   = 2'd1,
        FLT_NM   = 2'd2,
        FLT_MF   = 2'd3
    } fault_e;

    typedef enum logic {
        SEQ_IDLE   = 1'b0,
        SEQ_SECOND = 1'b1
    } seq_e;

    typedef enum logic [2:0] {
        LD_CW = 3'd0,
        LD_SW = 3'd1,
        LD_TW = 3'd2,
        LD_IP = 3'd3,
        LD_DP = 3'd4,
        LD_OP = 3'd5
    } ld_sel_e;

endpackage

// File: rtl/fpu_init_seq.sv
module fpu_init_seq
    import fpu_init_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic       cmd_wait,
    input  logic       cmd_lock,
    input  logic       sys_em,
    input  logic       sys_ts,
    input  logic       exc_pending,
    output logic       cmd_ready,
    output logic       do_init,
    output logic       busy,
    output logic       done,
    output fault_e     fault
);

    typedef struct packed {
        seq_e   st;
        logic   done;
        fault_e flt;
    } seq_s;

    seq_s seq_d, seq_q;
    logic sys_block;

    always_comb begin
        seq_d     = seq_q;
        seq_d.done = 1'b0;
        seq_d.flt  = FLT_NONE;
        do_init    = 1'b0;
        sys_block  = sys_em | sys_ts;
        case (seq_q.st)
            SEQ_IDLE: begin
                if (cmd_valid) begin
                    seq_d.done = 1'b1;
                    if (cmd_lock) begin
                        seq_d.flt = FLT_UD;
                    end else if (sys_block) begin
                        seq_d.flt = FLT_NM;
                    end else if (cmd_wait) begin
                        if (exc_pending) begin
                            seq_d.flt = FLT_MF;
                        end else begin
                            seq_d.st   = SEQ_SECOND;
                            seq_d.done = 1'b0;
                        end
                    end else begin
                        do_init = 1'b1;
                    end
                end
            end
            SEQ_SECOND: begin
                seq_d.st   = SEQ_IDLE;
                seq_d.done = 1'b1;
                if (sys_block) begin
                    seq_d.flt = FLT_NM;
                end else begin
                    do_init = 1'b1;
                end
            end
            default: seq_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: SEQ_IDLE, done: 1'b0, flt: FLT_NONE};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign cmd_ready = (seq_q.st == SEQ_IDLE);
    assign busy      = (cmd_ready && cmd_valid) || (seq_q.st == SEQ_SECOND);
    assign done      = seq_q.done;
    assign fault     = seq_q.flt;

endmodule

// File: rtl/fpu_init_regs.sv
module fpu_init_regs
    import fpu_init_pkg::*;
#(
    parameter int PTR_W    = 32,
    parameter int OP_W     = 11,
    parameter int NUM_TAGS = 8,
    localparam int TW_W    = 2 * NUM_TAGS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_init,
    input  logic             ld_block,
    input  logic             ld_en,
    input  logic [2:0]       ld_sel,
    input  logic [PTR_W-1:0] ld_data,
    output logic [15:0]      ctrl_word,
    output logic [15:0]      stat_word,
    output logic [TW_W-1:0]  tag_word,
    output logic [PTR_W-1:0] last_ip,
    output logic [PTR_W-1:0] last_dp,
    output logic [OP_W-1:0]  last_op
);

    typedef struct packed {
        logic [15:0]      cw;
        logic [15:0]      sw;
        logic [TW_W-1:0]  tw;
        logic [PTR_W-1:0] ip;
        logic [PTR_W-1:0] dp;
        logic [OP_W-1:0]  op;
    } regs_s;

    logic [TW_W-1:0] tw_empty;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_TAGS; gi++) begin : g_tag
            assign tw_empty[2*gi +: 2] = 2'b11;
        end
    endgenerate

    regs_s regs_d, regs_q, regs_init;

    always_comb begin
        regs_init = '{cw: CW_INIT, sw: SW_INIT, tw: tw_empty,
                      ip: '0, dp: '0, op: '0};
        regs_d = regs_q;
        if (do_init) begin
            regs_d = regs_init;
        end else if (ld_en && !ld_block) begin
            case (ld_sel)
                LD_CW:   regs_d.cw = ld_data[15:0];
                LD_SW:   regs_d.sw = ld_data[15:0];
                LD_TW:   regs_d.tw = ld_data[TW_W-1:0];
                LD_IP:   regs_d.ip = ld_data;
                LD_DP:   regs_d.dp = ld_data;
                LD_OP:   regs_d.op = ld_data[OP_W-1:0];
                default: regs_d = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{cw: CW_INIT, sw: SW_INIT, tw: {NUM_TAGS{2'b11}},
                        ip: '0, dp: '0, op: '0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign ctrl_word = regs_q.cw;
    assign stat_word = regs_q.sw;
    assign tag_word  = regs_q.tw;
    assign last_ip   = regs_q.ip;
    assign last_dp   = regs_q.dp;
    assign last_op   = regs_q.op;

endmodule

// File: rtl/fpu_init_ctrl.sv
module fpu_init_ctrl
    import fpu_init_pkg::*;
#(
    parameter int PTR_W    = 32,
    parameter int OP_W     = 11,
    parameter int NUM_TAGS = 8,
    localparam int TW_W    = 2 * NUM_TAGS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic             cmd_wait,
    input  logic             cmd_lock,
    input  logic             sys_em,
    input  logic             sys_ts,
    input  logic             exc_pending,
    input  logic             ld_en,
    input  logic [2:0]       ld_sel,
    input  logic [PTR_W-1:0] ld_data,
    output logic [15:0]      ctrl_word,
    output logic [15:0]      stat_word,
    output logic [TW_W-1:0]  tag_word,
    output logic [PTR_W-1:0] last_ip,
    output logic [PTR_W-1:0] last_dp,
    output logic [OP_W-1:0]  last_op,
    output logic             done,
    output logic [1:0]       fault_code,
    output logic             fault_ud,
    output logic             fault_nm,
    output logic             fault_mf
);

    logic   do_init;
    logic   busy;
    fault_e fault;

    fpu_init_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_wait    (cmd_wait),
        .cmd_lock    (cmd_lock),
        .sys_em      (sys_em),
        .sys_ts      (sys_ts),
        .exc_pending (exc_pending),
        .cmd_ready   (cmd_ready),
        .do_init     (do_init),
        .busy        (busy),
        .done        (done),
        .fault       (fault)
    );

    fpu_init_regs #(
        .PTR_W    (PTR_W),
        .OP_W     (OP_W),
        .NUM_TAGS (NUM_TAGS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .do_init   (do_init),
        .ld_block  (busy),
        .ld_en     (ld_en),
        .ld_sel    (ld_sel),
        .ld_data   (ld_data),
        .ctrl_word (ctrl_word),
        .stat_word (stat_word),
        .tag_word  (tag_word),
        .last_ip   (last_ip),
        .last_dp   (last_dp),
        .last_op   (last_op)
    );

    assign fault_code = fault;
    assign fault_ud   = done && (fault == FLT_UD);
    assign fault_nm   = done && (fault == FLT_NM);
    assign fault_mf   = done && (fault == FLT_MF);

endmodule

// File: rtl/fpu_init_chk.sv
module fpu_init_chk #(
    parameter int PTR_W    = 32,
    parameter int OP_W     = 11,
    parameter int NUM_TAGS = 8,
    localparam int TW_W    = 2 * NUM_TAGS
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic             cmd_wait,
    input logic             cmd_lock,
    input logic             sys_em,
    input logic             sys_ts,
    input logic             exc_pending,
    input logic [15:0]      ctrl_word,
    input logic [15:0]      stat_word,
    input logic [TW_W-1:0]  tag_word,
    input logic [PTR_W-1:0] last_ip,
    input logic [PTR_W-1:0] last_dp,
    input logic [OP_W-1:0]  last_op,
    input logic             done,
    input logic [1:0]       fault_code,
    input logic             fault_ud,
    input logic             fault_nm,
    input logic             fault_mf
);

    logic accept;
    assign accept = cmd_valid && cmd_ready;

    p_init_values_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault_code == 2'd0) |->
            (ctrl_word == 16'h037F && stat_word == 16'h0 && tag_word == '1 &&
             last_ip == '0 && last_dp == '0 && last_op == '0));

    p_nowait_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !cmd_wait) |=> (done && cmd_ready));

    p_pending_mf_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_wait && !cmd_lock && !sys_em && !sys_ts && exc_pending)
            |=> (done && fault_code == 2'd3));

    p_wait_second_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_wait && !cmd_lock && !sys_em && !sys_ts && !exc_pending)
            |=> (!cmd_ready && !done));

    p_sys_block_nm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !cmd_lock && (sys_em || sys_ts)) |=> (done && fault_code == 2'd2));

    p_lock_ud_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_lock) |=> (done && fault_code == 2'd1));

    p_fault_keeps_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault_code != 2'd0) |->
            ($stable(ctrl_word) && $stable(stat_word) && $stable(tag_word) &&
             $stable(last_ip) && $stable(last_dp) && $stable(last_op)));

    p_single_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fault_ud, fault_nm, fault_mf}));

    p_fault_needs_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_ud || fault_nm || fault_mf) |-> (done && fault_code != 2'd0));

endmodule

bind fpu_init_ctrl fpu_init_chk #(
    .PTR_W    (PTR_W),
    .OP_W     (OP_W),
    .NUM_TAGS (NUM_TAGS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_wait    (cmd_wait),
    .cmd_lock    (cmd_lock),
    .sys_em      (sys_em),
    .sys_ts      (sys_ts),
    .exc_pending (exc_pending),
    .ctrl_word   (ctrl_word),
    .stat_word   (stat_word),
    .tag_word    (tag_word),
    .last_ip     (last_ip),
    .last_dp     (last_dp),
    .last_op     (last_op),
    .done        (done),
    .fault_code  (fault_code),
    .fault_ud    (fault_ud),
    .fault_nm    (fault_nm),
    .fault_mf    (fault_mf)
);

// File: tb/fpu_init_ctrl_tb.sv
module fpu_init_ctrl_tb;

    localparam int PTR_W    = 48;
    localparam int OP_W     = 11;
    localparam int NUM_TAGS = 8;
    localparam int TW_W     = 2 * NUM_TAGS;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0;
    logic             cmd_ready;
    logic             cmd_wait = 1'b0;
    logic             cmd_lock = 1'b0;
    logic             sys_em = 1'b0;
    logic             sys_ts = 1'b0;
    logic             exc_pending = 1'b0;
    logic             ld_en = 1'b0;
    logic [2:0]       ld_sel = 3'd0;
    logic [PTR_W-1:0] ld_data = '0;
    logic [15:0]      ctrl_word;
    logic [15:0]      stat_word;
    logic [TW_W-1:0]  tag_word;
    logic [PTR_W-1:0] last_ip;
    logic [PTR_W-1:0] last_dp;
    logic [OP_W-1:0]  last_op;
    logic             done;
    logic [1:0]       fault_code;
    logic             fault_ud;
    logic             fault_nm;
    logic             fault_mf;

    always #2.5 clk = ~clk;

    fpu_init_ctrl #(.PTR_W(PTR_W), .OP_W(OP_W), .NUM_TAGS(NUM_TAGS)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_wait(cmd_wait), .cmd_lock(cmd_lock), .sys_em(sys_em), .sys_ts(sys_ts),
        .exc_pending(exc_pending), .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
        .ctrl_word(ctrl_word), .stat_word(stat_word), .tag_word(tag_word),
        .last_ip(last_ip), .last_dp(last_dp), .last_op(last_op), .done(done),
        .fault_code(fault_code), .fault_ud(fault_ud), .fault_nm(fault_nm),
        .fault_mf(fault_mf)
    );

    typedef struct {
        string            req;
        logic [1:0]       code;
        logic [15:0]      cw;
        logic [15:0]      sw;
        logic [TW_W-1:0]  tw;
        logic [PTR_W-1:0] ip;
        logic [PTR_W-1:0] dp;
        logic [OP_W-1:0]  op;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;

    logic [15:0]      m_cw = 16'h037F;
    logic [15:0]      m_sw = 16'h0;
    logic [TW_W-1:0]  m_tw = '1;
    logic [PTR_W-1:0] m_ip = '0;
    logic [PTR_W-1:0] m_dp = '0;
    logic [OP_W-1:0]  m_op = '0;

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_regs(string req);
        chk(req, "ctrl_word", 64'(ctrl_word), 64'(m_cw));
        chk(req, "stat_word", 64'(stat_word), 64'(m_sw));
        chk(req, "tag_word",  64'(tag_word),  64'(m_tw));
        chk(req, "last_ip",   64'(last_ip),   64'(m_ip));
        chk(req, "last_dp",   64'(last_dp),   64'(m_dp));
        chk(req, "last_op",   64'(last_op),   64'(m_op));
    endtask

    // Monitor: pops one expected item per done pulse
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R8 unexpected done actual=1 expected=0");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(e.req, "fault_code", 64'(fault_code), 64'(e.code));
                chk("R8", "fault_ud", 64'(fault_ud), 64'(e.code == 2'd1));
                chk("R8", "fault_nm", 64'(fault_nm), 64'(e.code == 2'd2));
                chk("R8", "fault_mf", 64'(fault_mf), 64'(e.code == 2'd3));
                chk(e.req, "ctrl_word", 64'(ctrl_word), 64'(e.cw));
                chk(e.req, "stat_word", 64'(stat_word), 64'(e.sw));
                chk(e.req, "tag_word",  64'(tag_word),  64'(e.tw));
                chk(e.req, "last_ip",   64'(last_ip),   64'(e.ip));
                chk(e.req, "last_dp",   64'(last_dp),   64'(e.dp));
                chk(e.req, "last_op",   64'(last_op),   64'(e.op));
            end
        end
    end

    task automatic load(logic [2:0] sel, logic [PTR_W-1:0] val);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = sel; ld_data = val;
        case (sel)
            3'd0: m_cw = val[15:0];
            3'd1: m_sw = val[15:0];
            3'd2: m_tw = val[TW_W-1:0];
            3'd3: m_ip = val;
            3'd4: m_dp = val;
            3'd5: m_op = val[OP_W-1:0];
            default: ;
        endcase
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic preset();
        load(3'd0, 48'h1234);
        load(3'd1, 48'h3A85);
        load(3'd2, 48'h0);
        load(3'd3, 48'hBEEF_0000_1234);
        load(3'd4, 48'hCAFE_0000_5678);
        load(3'd5, 48'h5A5);
    endtask

    // Driver: issues one command and pushes the expected completion
    task automatic issue(bit wt, bit lk, bit em, bit ts, bit pend, bit em2,
                         bit ldx, string req);
        exp_t e;
        bit   two_step;
        logic [1:0] code;
        if (lk)                  code = 2'd1;
        else if (em || ts)       code = 2'd2;
        else if (wt && pend)     code = 2'd3;
        else if (wt && em2)      code = 2'd2;
        else                     code = 2'd0;
        two_step = !lk && !(em || ts) && wt && !pend;
        if (code == 2'd0) begin
            m_cw = 16'h037F; m_sw = 16'h0; m_tw = '1;
            m_ip = '0; m_dp = '0; m_op = '0;
        end
        e.req = req; e.code = code;
        e.cw = m_cw; e.sw = m_sw; e.tw = m_tw;
        e.ip = m_ip; e.dp = m_dp; e.op = m_op;
        exp_q.push_back(e);
        @(negedge clk);
        chk(req, "cmd_ready before accept", 64'(cmd_ready), 64'd1);
        cmd_valid = 1'b1; cmd_wait = wt; cmd_lock = lk;
        sys_em = em; sys_ts = ts; exc_pending = pend;
        ld_en = ldx; ld_sel = 3'd0; ld_data = 48'hABCD;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_wait = 1'b0; cmd_lock = 1'b0;
        if (two_step) begin
            chk("R5", "cmd_ready in second step", 64'(cmd_ready), 64'd0);
            chk("R5", "done in second step", 64'(done), 64'd0);
            sys_em = em2; sys_ts = 1'b0; exc_pending = 1'b1;
            @(negedge clk);
        end else if (!wt) begin
            chk("R3", "cmd_ready after non-waiting", 64'(cmd_ready), 64'd1);
        end
        sys_em = 1'b0; sys_ts = 1'b0; exc_pending = 1'b0; ld_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: reset state
        chk_regs("R2");
        chk("R2", "cmd_ready", 64'(cmd_ready), 64'd1);
        chk("R2", "done", 64'(done), 64'd0);

        // R9: each load target, then unused codes do nothing
        preset();
        chk_regs("R9");
        load(3'd6, 48'hFFFF_FFFF_FFFF);
        load(3'd7, 48'hFFFF_FFFF_FFFF);
        chk_regs("R9");

        // R1 / R3: non-waiting initialize, pending exception ignored
        issue(0, 0, 0, 0, 1, 0, 0, "R3");
        @(negedge clk);
        chk_regs("R1");

        // R5: waiting form succeeds in two steps
        preset();
        issue(1, 0, 0, 0, 0, 0, 0, "R5");
        @(negedge clk);
        chk_regs("R1");

        // R4: waiting form with pending exception
        preset();
        issue(1, 0, 0, 0, 1, 0, 0, "R4");

        // R6: emulation bit and task-switched bit, each form
        issue(0, 0, 1, 0, 0, 0, 0, "R6");
        issue(1, 0, 0, 1, 1, 0, 0, "R6");
        // R6 / R10: second step blocked, load during both steps ignored
        issue(1, 0, 0, 0, 0, 1, 1, "R10");
        @(negedge clk);
        chk_regs("R10");

        // R7: lock prefix wins over every other fault, load in accept cycle ignored
        issue(0, 1, 1, 1, 1, 0, 1, "R7");
        issue(1, 1, 0, 0, 1, 0, 0, "R7");
        @(negedge clk);
        chk_regs("R7");

        // R8: priority NM over MF on waiting form
        issue(1, 0, 1, 0, 1, 0, 0, "R8");

        // back-to-back non-waiting commands
        issue(0, 0, 0, 0, 0, 0, 0, "R3");
        issue(0, 0, 0, 0, 0, 0, 0, "R1");

        repeat (4) @(negedge clk);
        chk("R8", "pending completions", 64'(exp_q.size()), 64'd0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule